// File: doc/BRIEF.md
# Microcoded Crypto Processing Element

This block is one tile of a processing mesh for byte-oriented cipher kernels. Each clock it takes one 11-bit horizontal control word and executes it completely in that cycle. Every field of the word steers the datapath directly, so there is no multi-cycle sequencing. The element holds eight 8-bit registers and a 64-byte scratch memory. Its ALU does bitwise AND and XOR, one-bit logical shifts, increment, decrement, and a substitution through a 256-entry byte table that can be reprogrammed. It exchanges bytes with its four neighbours through east, west, north and south ports.

A sequencer outside the block holds `run` high and presents one control word per cycle. While `run` is low the element is parked: control words are ignored, and the substitution table can be written through its own load port. Register R7 also acts as a memory pointer. It steps down after a read that uses R7 as the address and steps up after a write that uses R7 as the address, which makes sequential walks through the memory cheap.

Top module: `mcore_top`

## Requirements
- R1: While reset is high and on the first cycle after it, all output ports read 0 and `out_valid` is 0. All registers, memory and table entries start at 0.
- R2: Bits 8..6 name destination Rc, bits 5..3 name Rb and bits 2..0 name Ra. With bits 10:9 = 00 the element writes R[Rb] AND R[Ra] into R[Rc]. With bits 10:9 = 01 it writes R[Rb] XOR R[Ra] into R[Rc].
- R3: With bits 10:9 = 10, bits 2..0 select an operation on R[Rb] whose result goes to R[Rc]: 000 is the table lookup, 011 is a logical left shift by one, 100 is a logical right shift by one.
- R4: Bits 10..3 = 11111111 increment R[Ra] and bits 10..3 = 11111000 decrement it, both wrapping modulo 256.
- R5: With bits 10..6 = 11001 and bit 2 = 0, R[Rb] is loaded from the input port that bits 1..0 select (00 east, 01 west, 10 north, 11 south).
- R6: With bits 10..6 = 11001 and bit 2 = 1, R[Rb] is placed on the selected output port. That port's strobe in `out_valid` (bit 0 east, 1 west, 2 north, 3 south) is high for exactly the next cycle, and the byte stays on the port until that port is written again.
- R7: Bits 10..6 = 11100 load R[Ra] from memory at address R[Rb] mod 64. When Rb is 7, R7 is then decremented.
- R8: Bits 10..6 = 11010 store R[Rb] to memory at address R[Ra] mod 64. When Ra is 7, R7 is then incremented.
- R9: Bits 10..6 = 11011 copy R[Ra] into R[Rb].
- R10: While `run` is low the control word has no effect and no strobe fires. Table writes through the load port take effect only while `run` is low.
- R11: A memory read with both Ra and Rb equal to 7 leaves the loaded byte in R7, and the post-decrement is dropped.
- R12: Every other encoding (for example unary sub-codes 001, 010, 101–111, prefix 11111 with any other middle bits, or prefix 11000) changes no register, memory location or port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Execute the control word this cycle |
| cw | input | 11 | Horizontal control word |
| in_east | input | 8 | Byte from the east neighbour |
| in_west | input | 8 | Byte from the west neighbour |
| in_north | input | 8 | Byte from the north neighbour |
| in_south | input | 8 | Byte from the south neighbour |
| lut_we | input | 1 | Table write enable (honoured only while run is low) |
| lut_addr | input | 8 | Table write address |
| lut_wdata | input | 8 | Table write data |
| out_east | output | 8 | Byte held toward east |
| out_west | output | 8 | Byte held toward west |
| out_north | output | 8 | Byte held toward north |
| out_south | output | 8 | Byte held toward south |
| out_valid | output | 4 | One-cycle strobes, bit 0 east, 1 west, 2 north, 3 south |

## Verification
The collision of interest comes from a memory read that uses R7 both as the pointer and as the destination. In that cycle the data load and the pointer decrement reach the same register. The bench sets up this case on purpose: it places a known byte at the R7 address, issues the read with Ra = Rb = 7, and then sends R7 out of a port. The byte read back must be the loaded value and not the decremented pointer. A second overlap is a table write offered while `run` is high. It is judged by a later lookup at that address, which must return the old entry.

// File: rtl/mcore_pkg.sv
package mcore_pkg;

    localparam int DW        = 8;
    localparam int NREG      = 8;
    localparam int RW        = $clog2(NREG);
    localparam int CW_W      = 11;
    localparam int MEM_DEPTH = 64;
    localparam int LUT_DEPTH = 256;
    localparam int NPORT     = 4;
    localparam int PW        = $clog2(NPORT);

    typedef logic [DW-1:0] byte_t;

    typedef enum logic [3:0] {
        OP_NOP, OP_AND, OP_XOR, OP_LUT, OP_SHL, OP_SHR,
        OP_INC, OP_DEC, OP_IN,  OP_OUT, OP_MRD, OP_MWR, OP_MOV
    } op_e;

    typedef struct packed {
        op_e           op;
        logic [RW-1:0] ra;
        logic [RW-1:0] rb;
        logic [RW-1:0] rc;
        logic [PW-1:0] port;
    } dec_t;

    function automatic dec_t decode_cw(input logic [CW_W-1:0] c);
        dec_t d;
        d.ra   = c[2:0];
        d.rb   = c[5:3];
        d.rc   = c[8:6];
        d.port = c[1:0];
        d.op   = OP_NOP;
        unique case (c[10:9])
            2'b00: d.op = OP_AND;
            2'b01: d.op = OP_XOR;
            2'b10: begin
                case (c[2:0])
                    3'b000:  d.op = OP_LUT;
                    3'b011:  d.op = OP_SHL;
                    3'b100:  d.op = OP_SHR;
                    default: d.op = OP_NOP;
                endcase
            end
            default: begin
                if (c[10:3] == 8'hFF)      d.op = OP_INC;
                else if (c[10:3] == 8'hF8) d.op = OP_DEC;
                else begin
                    case (c[10:6])
                        5'b11001: d.op = c[2] ? OP_OUT : OP_IN;
                        5'b11100: d.op = OP_MRD;
                        5'b11010: d.op = OP_MWR;
                        5'b11011: d.op = OP_MOV;
                        default:  d.op = OP_NOP;
                    endcase
                end
            end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/mcore_alu.sv
module mcore_alu
    import mcore_pkg::*;
(
    input  op_e         op,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic [DW-1:0] lut_q,
    output logic [DW-1:0] y
);
    always_comb begin
        case (op)
            OP_AND:  y = opb & opa;
            OP_XOR:  y = opb ^ opa;
            OP_LUT:  y = lut_q;
            OP_SHL:  y = {opb[DW-2:0], 1'b0};
            OP_SHR:  y = {1'b0, opb[DW-1:1]};
            OP_INC:  y = opa + DW'(1);
            OP_DEC:  y = opa - DW'(1);
            OP_MOV:  y = opa;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/mcore_regfile.sv
module mcore_regfile #(
    parameter int DW   = 8,
    parameter int NREG = 8,
    localparam int RW  = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [RW-1:0]            waddr,
    input  logic [DW-1:0]            wdata,
    input  logic                     step_en,
    input  logic                     step_dn,
    output logic [NREG-1:0][DW-1:0]  regs
);
    localparam int PTR = NREG - 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else begin
            if (step_en)
                regs[PTR] <= step_dn ? regs[PTR] - DW'(1) : regs[PTR] + DW'(1);
            if (we)
                regs[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/mcore_lut.sv
module mcore_lut #(
    parameter int DW    = 8,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] tbl_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) tbl_q[i] <= '0;
        end else if (we) begin
            tbl_q[waddr] <= wdata;
        end
    end

    assign rdata = tbl_q[raddr];
endmodule

// File: rtl/mcore_top.sv
module mcore_top
    import mcore_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        run,
    input  logic [10:0] cw,
    input  logic [7:0]  in_east,
    input  logic [7:0]  in_west,
    input  logic [7:0]  in_north,
    input  logic [7:0]  in_south,
    input  logic        lut_we,
    input  logic [7:0]  lut_addr,
    input  logic [7:0]  lut_wdata,
    output logic [7:0]  out_east,
    output logic [7:0]  out_west,
    output logic [7:0]  out_north,
    output logic [7:0]  out_south,
    output logic [3:0]  out_valid
);
    localparam int MA_W = $clog2(MEM_DEPTH);
    localparam int LA_W = $clog2(LUT_DEPTH);
    localparam logic [RW-1:0] PTR_IDX = RW'(NREG - 1);

    dec_t                    dec;
    logic [NREG-1:0][DW-1:0] regs_q;
    logic [DW-1:0]           rd_a, rd_b, alu_y, lut_q, mem_rdata;
    logic [NPORT-1:0][DW-1:0] pin;
    logic [NPORT-1:0][DW-1:0] pout_q;
    logic [NPORT-1:0]        pval_q;
    logic                    wr_en, step_en, step_dn, mem_we, out_fire;
    logic [RW-1:0]           wr_addr;
    logic [DW-1:0]           wr_data;
    logic [DW-1:0]           mem_q [MEM_DEPTH];

    assign dec  = decode_cw(cw);
    assign rd_a = regs_q[dec.ra];
    assign rd_b = regs_q[dec.rb];
    assign pin  = {in_south, in_north, in_west, in_east};

    mcore_alu u_alu (
        .op    (dec.op),
        .opa   (rd_a),
        .opb   (rd_b),
        .lut_q (lut_q),
        .y     (alu_y)
    );

    mcore_lut #(.DW(DW), .DEPTH(LUT_DEPTH)) u_lut (
        .clk   (clk),
        .rst   (rst),
        .we    (lut_we && !run),
        .waddr (lut_addr[LA_W-1:0]),
        .wdata (lut_wdata),
        .raddr (rd_b[LA_W-1:0]),
        .rdata (lut_q)
    );

    assign mem_rdata = mem_q[rd_b[MA_W-1:0]];

    always_comb begin
        wr_en    = 1'b0;
        wr_addr  = dec.rc;
        wr_data  = alu_y;
        step_en  = 1'b0;
        step_dn  = 1'b0;
        mem_we   = 1'b0;
        out_fire = 1'b0;
        if (run) begin
            case (dec.op)
                OP_AND, OP_XOR, OP_LUT, OP_SHL, OP_SHR: begin
                    wr_en   = 1'b1;
                    wr_addr = dec.rc;
                end
                OP_INC, OP_DEC: begin
                    wr_en   = 1'b1;
                    wr_addr = dec.ra;
                end
                OP_MOV: begin
                    wr_en   = 1'b1;
                    wr_addr = dec.rb;
                end
                OP_IN: begin
                    wr_en   = 1'b1;
                    wr_addr = dec.rb;
                    wr_data = pin[dec.port];
                end
                OP_MRD: begin
                    wr_en   = 1'b1;
                    wr_addr = dec.ra;
                    wr_data = mem_rdata;
                    step_en = (dec.rb == PTR_IDX);
                    step_dn = 1'b1;
                end
                OP_MWR: begin
                    mem_we  = 1'b1;
                    step_en = (dec.ra == PTR_IDX);
                end
                OP_OUT:  out_fire = 1'b1;
                default: ;
            endcase
        end
    end

    mcore_regfile #(.DW(DW), .NREG(NREG)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_en),
        .waddr   (wr_addr),
        .wdata   (wr_data),
        .step_en (step_en),
        .step_dn (step_dn),
        .regs    (regs_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_DEPTH; i++) mem_q[i] <= '0;
        end else if (mem_we) begin
            mem_q[rd_a[MA_W-1:0]] <= rd_b;
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        always_ff @(posedge clk) begin
            if (rst) begin
                pout_q[p] <= '0;
                pval_q[p] <= 1'b0;
            end else if (out_fire && dec.port == PW'(p)) begin
                pout_q[p] <= rd_b;
                pval_q[p] <= 1'b1;
            end else begin
                pval_q[p] <= 1'b0;
            end
        end
    end

    assign out_east  = pout_q[0];
    assign out_west  = pout_q[1];
    assign out_north = pout_q[2];
    assign out_south = pout_q[3];
    assign out_valid = pval_q;

endmodule

// File: rtl/mcore_checker.sv
module mcore_checker (
    input logic            clk,
    input logic            rst,
    input logic            run,
    input logic [10:0]     cw,
    input logic [3:0]      out_valid,
    input logic [7:0][7:0] regs
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (out_valid == 4'b0000));

    a_r6_single_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0(out_valid));

    a_r10_idle_no_strobe: assert property (@(posedge clk) disable iff (rst)
        !run |=> (out_valid == 4'b0000));

    a_r8_ptr_up: assert property (@(posedge clk) disable iff (rst)
        (run && cw[10:6] == 5'b11010 && cw[2:0] == 3'd7)
        |=> regs[7] == $past(regs[7]) + 8'd1);

    a_r7_ptr_down: assert property (@(posedge clk) disable iff (rst)
        (run && cw[10:6] == 5'b11100 && cw[5:3] == 3'd7 && cw[2:0] != 3'd7)
        |=> regs[7] == $past(regs[7]) - 8'd1);

    a_r4_increment: assert property (@(posedge clk) disable iff (rst)
        (run && cw[10:3] == 8'hFF)
        |=> regs[$past(cw[2:0])] == $past(regs[cw[2:0]]) + 8'd1);
endmodule

bind mcore_top mcore_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .cw        (cw),
    .out_valid (out_valid),
    .regs      (regs_q)
);

// File: tb/mcore_top_bench.sv
module mcore_top_bench;
    logic        clk = 1'b0;
    logic        rst, run, lut_we;
    logic [10:0] cw;
    logic [7:0]  in_east, in_west, in_north, in_south, lut_addr, lut_wdata;
    logic [7:0]  out_east, out_west, out_north, out_south;
    logic [3:0]  out_valid;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_r   [8];
    logic [7:0] m_mem [64];
    logic [7:0] m_lut [256];
    logic [7:0] m_out [4];
    logic [3:0] m_val;

    always #10 clk = ~clk;

    mcore_top u_mcore_top (
        .clk(clk), .rst(rst), .run(run), .cw(cw),
        .in_east(in_east), .in_west(in_west), .in_north(in_north), .in_south(in_south),
        .lut_we(lut_we), .lut_addr(lut_addr), .lut_wdata(lut_wdata),
        .out_east(out_east), .out_west(out_west), .out_north(out_north),
        .out_south(out_south), .out_valid(out_valid)
    );

    function automatic logic [10:0] f_and(int rc, int rb, int ra);
        return {2'b00, 3'(rc), 3'(rb), 3'(ra)};
    endfunction
    function automatic logic [10:0] f_xor(int rc, int rb, int ra);
        return {2'b01, 3'(rc), 3'(rb), 3'(ra)};
    endfunction
    function automatic logic [10:0] f_un(int rc, int rb, int sub);
        return {2'b10, 3'(rc), 3'(rb), 3'(sub)};
    endfunction
    function automatic logic [10:0] f_inc(int ra);
        return {8'hFF, 3'(ra)};
    endfunction
    function automatic logic [10:0] f_dec(int ra);
        return {8'hF8, 3'(ra)};
    endfunction
    function automatic logic [10:0] f_in(int rb, int p);
        return {5'b11001, 3'(rb), 1'b0, 2'(p)};
    endfunction
    function automatic logic [10:0] f_out(int rb, int p);
        return {5'b11001, 3'(rb), 1'b1, 2'(p)};
    endfunction
    function automatic logic [10:0] f_mrd(int ra, int rb);
        return {5'b11100, 3'(rb), 3'(ra)};
    endfunction
    function automatic logic [10:0] f_mwr(int ra, int rb);
        return {5'b11010, 3'(rb), 3'(ra)};
    endfunction
    function automatic logic [10:0] f_mov(int rb, int ra);
        return {5'b11011, 3'(rb), 3'(ra)};
    endfunction

    // Reference behaviour, built from the requirement list
    task automatic model_exec(input logic [10:0] c, input logic go);
        logic [7:0] ins [4];
        logic [7:0] tmp;
        int ra, rb, rc;
        ins[0] = in_east; ins[1] = in_west; ins[2] = in_north; ins[3] = in_south;
        ra = int'(c[2:0]); rb = int'(c[5:3]); rc = int'(c[8:6]);
        m_val = 4'b0000;
        if (!go) begin
            if (lut_we) m_lut[lut_addr] = lut_wdata;   // R10
            return;
        end
        if (c[10:9] == 2'b00) m_r[rc] = m_r[rb] & m_r[ra];
        else if (c[10:9] == 2'b01) m_r[rc] = m_r[rb] ^ m_r[ra];
        else if (c[10:9] == 2'b10) begin
            if (ra == 0)      m_r[rc] = m_lut[m_r[rb]];
            else if (ra == 3) m_r[rc] = m_r[rb] << 1;
            else if (ra == 4) m_r[rc] = m_r[rb] >> 1;
        end else if (c[10:3] == 8'hFF) m_r[ra] = m_r[ra] + 8'd1;
        else if (c[10:3] == 8'hF8) m_r[ra] = m_r[ra] - 8'd1;
        else if (c[10:6] == 5'b11001) begin
            if (c[2]) begin
                m_out[c[1:0]] = m_r[rb];
                m_val[c[1:0]] = 1'b1;
            end else m_r[rb] = ins[c[1:0]];
        end else if (c[10:6] == 5'b11100) begin
            tmp = m_mem[m_r[rb] % 64];
            if (rb == 7) m_r[7] = m_r[7] - 8'd1;
            m_r[ra] = tmp;                             // R11: load wins
        end else if (c[10:6] == 5'b11010) begin
            m_mem[m_r[ra] % 64] = m_r[rb];
            if (ra == 7) m_r[7] = m_r[7] + 8'd1;
        end else if (c[10:6] == 5'b11011) m_r[rb] = m_r[ra];
    endtask

    task automatic compare(input string tag);
        checks++;
        if ({out_east, out_west, out_north, out_south, out_valid} !==
            {m_out[0], m_out[1], m_out[2], m_out[3], m_val}) begin
            errors++;
            $display("FAIL %s: got e=%h w=%h n=%h s=%h v=%b expected e=%h w=%h n=%h s=%h v=%b",
                     tag, out_east, out_west, out_north, out_south, out_valid,
                     m_out[0], m_out[1], m_out[2], m_out[3], m_val);
        end
    endtask

    task automatic step(input logic [10:0] c, input logic go, input string tag);
        cw  = c;
        run = go;
        model_exec(c, go);
        @(negedge clk);
        compare(tag);
        lut_we = 1'b0;
    endtask

    task automatic set_reg(input int r, input logic [7:0] v, input int p, input string tag);
        case (p)
            0: in_east = v;
            1: in_west = v;
            2: in_north = v;
            default: in_south = v;
        endcase
        step(f_in(r, p), 1'b1, tag);
    endtask

    task automatic dump(input string tag);
        for (int r = 0; r < 8; r++) step(f_out(r, r % 4), 1'b1, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [10:0] c;
        void'($urandom(32'd20240611));
        rst = 1'b1; run = 1'b0; cw = '0; lut_we = 1'b0; lut_addr = '0; lut_wdata = '0;
        in_east = '0; in_west = '0; in_north = '0; in_south = '0;
        for (int i = 0; i < 8; i++)   m_r[i] = '0;
        for (int i = 0; i < 64; i++)  m_mem[i] = '0;
        for (int i = 0; i < 256; i++) m_lut[i] = '0;
        for (int i = 0; i < 4; i++)   m_out[i] = '0;
        m_val = '0;
        repeat (3) @(negedge clk);
        compare("R1 in reset");
        rst = 1'b0;
        @(negedge clk);
        compare("R1 after reset");
        dump("R1");

        // Load the substitution table while parked
        for (int i = 0; i < 256; i++) begin
            lut_we = 1'b1; lut_addr = 8'(i); lut_wdata = 8'(i * 29 + 11);
            step(11'd0, 1'b0, "R10 load");
        end

        // R5: one port each
        set_reg(1, 8'hC3, 0, "R5"); set_reg(2, 8'h5A, 1, "R5");
        set_reg(3, 8'h81, 2, "R5"); set_reg(4, 8'h7E, 3, "R5");
        dump("R5");

        // R6: strobe per direction, then hold
        for (int p = 0; p < 4; p++) step(f_out(p + 1, p), 1'b1, "R6");
        step(11'b11000_000_000, 1'b1, "R6 hold");

        // R2
        step(f_and(5, 1, 2), 1'b1, "R2"); step(f_xor(6, 3, 4), 1'b1, "R2");
        dump("R2");

        // R3
        step(f_un(0, 1, 0), 1'b1, "R3");
        set_reg(2, 8'h81, 0, "R3");
        step(f_un(5, 2, 3), 1'b1, "R3"); step(f_un(6, 2, 4), 1'b1, "R3");
        dump("R3");

        // R4: wrap in both directions
        set_reg(0, 8'hFF, 1, "R4"); step(f_inc(0), 1'b1, "R4");
        set_reg(1, 8'h00, 1, "R4"); step(f_dec(1), 1'b1, "R4");
        dump("R4");

        // R8: write through R7, post-increment across the 64 boundary
        set_reg(7, 8'h3E, 2, "R8"); set_reg(1, 8'hA5, 2, "R8"); set_reg(2, 8'h3C, 2, "R8");
        step(f_mwr(7, 1), 1'b1, "R8"); step(f_mwr(7, 2), 1'b1, "R8");
        step(f_mwr(7, 7), 1'b1, "R8");
        dump("R8");

        // R7: read mod 64, then read through R7 with post-decrement
        set_reg(6, 8'h7E, 3, "R7"); step(f_mrd(0, 6), 1'b1, "R7");
        set_reg(7, 8'h3F, 3, "R7"); step(f_mrd(3, 7), 1'b1, "R7");
        dump("R7");

        // R11: pointer is also the destination
        set_reg(7, 8'h3F, 0, "R11"); step(f_mrd(7, 7), 1'b1, "R11");
        dump("R11");

        // R9
        step(f_mov(5, 1), 1'b1, "R9"); dump("R9");

        // R10: parked word ignored; running table write ignored
        step(f_inc(0), 1'b0, "R10"); step(f_out(0, 0), 1'b0, "R10");
        lut_we = 1'b1; lut_addr = 8'h05; lut_wdata = 8'hEE;
        step(f_and(4, 4, 4), 1'b1, "R10");
        set_reg(1, 8'h05, 0, "R10"); step(f_un(2, 1, 0), 1'b1, "R10");
        dump("R10");

        // R12: unused encodings
        step(11'b10_000_001_001, 1'b1, "R12"); step(11'b10_011_010_110, 1'b1, "R12");
        step(11'b11111_010_000, 1'b1, "R12"); step(11'b11000_101_101, 1'b1, "R12");
        step(11'b11101_001_010, 1'b1, "R12");
        dump("R12");

        // Random mix
        for (int n = 0; n < 1500; n++) begin
            in_east = 8'($urandom); in_west = 8'($urandom);
            in_north = 8'($urandom); in_south = 8'($urandom);
            case ($urandom % 11)
                0:  c = f_and($urandom % 8, $urandom % 8, $urandom % 8);
                1:  c = f_xor($urandom % 8, $urandom % 8, $urandom % 8);
                2:  c = f_un($urandom % 8, $urandom % 8, ($urandom % 2) ? 0 : 3 + ($urandom % 2));
                3:  c = ($urandom % 2) ? f_inc($urandom % 8) : f_dec($urandom % 8);
                4:  c = f_in($urandom % 8, $urandom % 4);
                5:  c = f_out($urandom % 8, $urandom % 4);
                6:  c = f_mrd($urandom % 8, ($urandom % 2) ? 7 : $urandom % 8);
                7:  c = f_mwr(($urandom % 2) ? 7 : $urandom % 8, $urandom % 8);
                8:  c = f_mov($urandom % 8, $urandom % 8);
                9:  c = 11'($urandom);
                default: c = f_out($urandom % 8, $urandom % 4);
            endcase
            step(c, ($urandom % 8) != 0, "R6 random");
        end
        dump("R2 final");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule